// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the two timing clocks of a stereo serial audio port: a bit clock and a left/right frame clock. In master mode it derives them from its own clock input, which is the master audio clock. A first divider of 2 or 4 master cycles forms one bit period. A second divider of 32, 64 or 128 bit periods forms one stereo frame. Each clock has its own polarity control. An optional gating mode parks the bit clock outside the active data slots of each half frame.

In slave mode the block drives no clocks. The externally supplied bit and frame clocks pass through a two-stage synchroniser and into edge detectors. In both modes the block emits one-cycle strobes that a data path uses: one for the data-change edge, one for the data-capture edge, and one for the start of a frame. A global enable holds the dividers at zero while low, so the first frame after enable always opens with the left word.

Top module: `aclk_gen`

## Requirements
- R1: During reset the strobes, `bclk_o` and `lrclk_o` are low. While `enable_i` is low in master mode, all strobes stay low and, from the second cycle on, `bclk_o` rests at `bclk_inv_i` and `lrclk_o` at `lr_inv_i`.
- R2: In master mode `shift_o` pulses every 2 master cycles when `mdiv_sel_i`=0 and every 4 when it is 1. `sample_o` pulses half a bit period after each `shift_o`.
- R3: A frame lasts 32, 64 or 128 bit periods for `fdiv_sel_i` = 0, 1 or 2. Code 3 is treated as 128.
- R4: `lrclk_o` equals `lr_inv_i` for the first half of each frame (the left word) and its complement for the second half. It changes only in cycles where `shift_o` is high.
- R5: With `bclk_inv_i`=0, every falling edge of `bclk_o` comes with `shift_o` and every rising edge with `sample_o`. With `bclk_inv_i`=1 the roles of the two edges swap.
- R6: `frame_start_o` pulses once per frame, in a cycle where `shift_o` is also high and `lrclk_o` shows the left level.
- R7: With `free_run_i`=1 the bit clock toggles in every bit period. With `free_run_i`=0 it toggles only during the first ACTIVE_BITS slots of each half frame and rests at `bclk_inv_i` otherwise. The strobes continue during gated slots.
- R8: After `enable_i` rises, even following a stop in mid-frame, the first `shift_o` pulse also carries `frame_start_o`.
- R9: With `master_i`=0, `clk_oe_o`, `bclk_o` and `lrclk_o` are low. Each external edge of the selected polarity on `bclk_i` yields exactly one `shift_o` pulse, and each opposite edge yields one `sample_o` pulse.
- R10: In slave mode `frame_start_o` pulses at the first shift edge at which the synchronised `lrclk_i` shows the left level after showing the right level at the previous shift edge. It always pulses together with `shift_o`.
- R11: `shift_o` and `sample_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Global enable; low holds dividers at zero and strobes off |
| master_i | input | 1 | 1 generates clocks, 0 follows external clocks |
| mdiv_sel_i | input | 1 | Master cycles per bit: 0 gives 2, 1 gives 4 |
| fdiv_sel_i | input | 2 | Bits per frame: 0 gives 32, 1 gives 64, 2 and 3 give 128 |
| bclk_inv_i | input | 1 | 0 shifts on falling bit-clock edge, 1 on rising |
| lr_inv_i | input | 1 | Frame clock level during the left word |
| free_run_i | input | 1 | 1 keeps the bit clock running through unused slots |
| bclk_i | input | 1 | External bit clock used in slave mode |
| lrclk_i | input | 1 | External frame clock used in slave mode |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| clk_oe_o | output | 1 | Drive enable for both clock pins |
| shift_o | output | 1 | One-cycle strobe at each data-change edge |
| sample_o | output | 1 | One-cycle strobe at each data-capture edge |
| frame_start_o | output | 1 | One-cycle strobe at the first bit of a frame |

## Verification
The frame-start strobe, a shift strobe and a frame-clock transition all fall in the same cycle at every frame boundary. The bench judges this by requiring `shift_o` and the left frame level in every cycle that shows `frame_start_o`, and by requiring a shift strobe with every frame-clock change. A second overlap comes from a stop request that lands right after a frame boundary, and a restart that follows a stop in mid-frame. The bench provokes both and checks that the first shift strobe after the restart carries the frame start. Frame length, bit-clock edge count and left-level duration per frame are queued by the driver and compared by the monitor at each frame start.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int unsigned MaxMclkPerBit   = 4;
  localparam int unsigned MaxBitsPerFrame = 128;
  localparam int unsigned MCW = $clog2(MaxMclkPerBit);
  localparam int unsigned BCW = $clog2(MaxBitsPerFrame);
  localparam int unsigned FW  = BCW + 1;

  typedef enum logic {
    BIT_DIV2 = 1'b0,
    BIT_DIV4 = 1'b1
  } bit_ratio_e;

  typedef enum logic [1:0] {
    FRM_32     = 2'd0,
    FRM_64     = 2'd1,
    FRM_128    = 2'd2,
    FRM_128_X  = 2'd3
  } frame_ratio_e;

  typedef struct packed {
    logic shift;
    logic sample;
    logic frame_start;
  } strobe_t;

  function automatic logic [MCW:0] bit_mclks(bit_ratio_e sel);
    return (sel == BIT_DIV4) ? (MCW+1)'(4) : (MCW+1)'(2);
  endfunction

  function automatic logic [FW-1:0] frame_bits(frame_ratio_e sel);
    logic [FW-1:0] n;
    case (sel)
      FRM_32:  n = FW'(32);
      FRM_64:  n = FW'(64);
      default: n = FW'(128);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aclk_sync.sv
module aclk_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/aclk_master_div.sv
module aclk_master_div
  import aclk_pkg::*;
#(
  parameter int unsigned ACTIVE_BITS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  bit_ratio_e   bsel,
  input  frame_ratio_e fsel,
  input  logic         bclk_inv,
  input  logic         lr_inv,
  input  logic         free_run,
  output logic         bclk_q,
  output logic         lrclk_q,
  output strobe_t      stb_q
);

  localparam logic [FW-1:0] ActLim = FW'(ACTIVE_BITS);

  logic [MCW-1:0] mcnt_q, mcnt_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [MCW:0]   per_bit, half_bit, mpos;
  logic [FW-1:0]  per_frame, half_frame, bpos, slot;
  logic           bit_last, frame_last, right_half, slot_active, raw_bclk;

  always_comb begin
    per_bit     = bit_mclks(bsel);
    half_bit    = per_bit >> 1;
    per_frame   = frame_bits(fsel);
    half_frame  = per_frame >> 1;
    mpos        = {1'b0, mcnt_q};
    bpos        = {1'b0, bcnt_q};
    bit_last    = mpos >= (per_bit - 1'b1);
    frame_last  = bpos >= (per_frame - 1'b1);
    right_half  = bpos >= half_frame;
    slot        = right_half ? (bpos - half_frame) : bpos;
    slot_active = free_run || (slot < ActLim);
    raw_bclk    = mpos >= half_bit;
  end

  // Dividers: held at zero while stopped so that a restart opens a left word.
  always_comb begin
    mcnt_d = mcnt_q;
    bcnt_d = bcnt_q;
    if (!run) begin
      mcnt_d = '0;
      bcnt_d = '0;
    end else if (bit_last) begin
      mcnt_d = '0;
      bcnt_d = frame_last ? '0 : bcnt_q + 1'b1;
    end else begin
      mcnt_d = mcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt_q  <= '0;
      bcnt_q  <= '0;
      bclk_q  <= 1'b0;
      lrclk_q <= 1'b0;
      stb_q   <= '0;
    end else begin
      mcnt_q <= mcnt_d;
      bcnt_q <= bcnt_d;
      if (run) begin
        bclk_q            <= (raw_bclk & slot_active) ^ bclk_inv;
        lrclk_q           <= right_half ^ lr_inv;
        stb_q.shift       <= (mcnt_q == '0);
        stb_q.sample      <= (mpos == half_bit);
        stb_q.frame_start <= (mcnt_q == '0) && (bcnt_q == '0);
      end else begin
        bclk_q  <= bclk_inv;
        lrclk_q <= lr_inv;
        stb_q   <= '0;
      end
    end
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_q.shift && stb_q.sample));

  p_frame_on_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q.frame_start |-> stb_q.shift);

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (stb_q == '0));

  p_left_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb_q.frame_start) |-> (lrclk_q == $past(lr_inv)));

endmodule

// File: rtl/aclk_slave_edge.sv
module aclk_slave_edge
  import aclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    bclk_inv,
  input  logic    lr_inv,
  input  logic    ext_bclk,
  input  logic    ext_lrclk,
  output strobe_t stb_q
);

  logic [1:0] synced;
  logic       bclk_s, lr_s, bclk_d;
  logic       rise, fall, shift_e, sample_e, at_left, last_left;

  aclk_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_lrclk, ext_bclk}),
    .q     (synced)
  );

  assign bclk_s = synced[0];
  assign lr_s   = synced[1];

  always_comb begin
    rise     = bclk_s & ~bclk_d;
    fall     = ~bclk_s & bclk_d;
    shift_e  = bclk_inv ? rise : fall;
    sample_e = bclk_inv ? fall : rise;
    at_left  = (lr_s == lr_inv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d    <= 1'b0;
      last_left <= 1'b1;
      stb_q     <= '0;
    end else begin
      bclk_d <= bclk_s;
      if (!run) begin
        last_left <= 1'b1;
        stb_q     <= '0;
      end else begin
        stb_q.shift       <= shift_e;
        stb_q.sample      <= sample_e;
        stb_q.frame_start <= shift_e & at_left & ~last_left;
        if (shift_e) last_left <= at_left;
      end
    end
  end

  p_slv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (stb_q == '0));

  p_slv_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_q.shift && stb_q.sample));

  p_slv_fs_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q.frame_start |-> stb_q.shift);

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned ACTIVE_BITS = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       master_i,
  input  logic       mdiv_sel_i,
  input  logic [1:0] fdiv_sel_i,
  input  logic       bclk_inv_i,
  input  logic       lr_inv_i,
  input  logic       free_run_i,
  input  logic       bclk_i,
  input  logic       lrclk_i,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       clk_oe_o,
  output logic       shift_o,
  output logic       sample_o,
  output logic       frame_start_o
);

  logic    run_m, run_s, m_bclk, m_lrclk;
  strobe_t m_stb, s_stb, sel_stb;

  assign run_m = enable_i & master_i;
  assign run_s = enable_i & ~master_i;

  aclk_master_div #(.ACTIVE_BITS(ACTIVE_BITS)) u_master (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .run      (run_m),
    .bsel     (bit_ratio_e'(mdiv_sel_i)),
    .fsel     (frame_ratio_e'(fdiv_sel_i)),
    .bclk_inv (bclk_inv_i),
    .lr_inv   (lr_inv_i),
    .free_run (free_run_i),
    .bclk_q   (m_bclk),
    .lrclk_q  (m_lrclk),
    .stb_q    (m_stb)
  );

  aclk_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_slave (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .run       (run_s),
    .bclk_inv  (bclk_inv_i),
    .lr_inv    (lr_inv_i),
    .ext_bclk  (bclk_i),
    .ext_lrclk (lrclk_i),
    .stb_q     (s_stb)
  );

  assign sel_stb       = master_i ? m_stb : s_stb;
  assign bclk_o        = master_i & m_bclk;
  assign lrclk_o       = master_i & m_lrclk;
  assign clk_oe_o      = master_i;
  assign shift_o       = sel_stb.shift;
  assign sample_o      = sel_stb.sample;
  assign frame_start_o = sel_stb.frame_start;

endmodule

// File: tb/aclk_gen_tb_top.sv
`timescale 1ns/1ps
module aclk_gen_tb_top;

  localparam int ACT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, mst = 1'b1, mdiv = 1'b0, binv = 1'b0, linv = 1'b0, frun = 1'b1;
  logic [1:0] fdiv = 2'd0;
  logic ext_b = 1'b0, ext_l = 1'b0;
  logic bclk_o, lrclk_o, clk_oe_o, shift_o, sample_o, frame_start_o;

  always #4 clk = ~clk;

  aclk_gen #(.ACTIVE_BITS(ACT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .master_i(mst),
    .mdiv_sel_i(mdiv), .fdiv_sel_i(fdiv), .bclk_inv_i(binv), .lr_inv_i(linv),
    .free_run_i(frun), .bclk_i(ext_b), .lrclk_i(ext_l),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .clk_oe_o(clk_oe_o),
    .shift_o(shift_o), .sample_o(sample_o), .frame_start_o(frame_start_o)
  );

  typedef struct { int period; int edges; int left; } exp_t;
  exp_t exp_q[$];
  exp_t cur_e;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit mon_m = 1'b0, mon_s = 1'b0, first_pend = 1'b0;
  int exp_per = 2;
  int gcyc = 0, last_sh = 0, cyc_cnt = 0, edge_cnt = 0, left_cnt = 0;
  bit have_sh = 1'b0, have_fs = 1'b0;
  logic prev_b = 1'b0, prev_l = 1'b0;
  int viol11 = 0, sh_cnt = 0, sa_cnt = 0, fs_cnt = 0, drv_bad = 0, fs_bad = 0;

  task automatic chk(input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // Monitor: samples 2 ns after each rising edge, pops the scoreboard at frame starts.
  always @(posedge clk) begin
    #2;
    gcyc++;
    if (mon_m) begin
      cyc_cnt++;
      if (shift_o && sample_o) viol11++;
      if (bclk_o !== prev_b) begin
        if (bclk_o == binv) begin
          edge_cnt++;
          chk("R5 shift strobe at shift-polarity bclk edge", int'(shift_o), 1);
        end else begin
          chk("R5 sample strobe at sample-polarity bclk edge", int'(sample_o), 1);
        end
      end
      if (lrclk_o !== prev_l) chk("R4 lrclk changes only with shift", int'(shift_o), 1);
      if (lrclk_o == linv) left_cnt++;
      if (shift_o) begin
        if (have_sh) chk("R2 shift interval", gcyc - last_sh, exp_per);
        last_sh = gcyc;
        have_sh = 1'b1;
        if (first_pend) begin
          chk("R8 first shift after enable is frame start", int'(frame_start_o), 1);
          first_pend = 1'b0;
        end
      end
      if (sample_o && have_sh) chk("R2 sample half a bit after shift", gcyc - last_sh, exp_per / 2);
      if (frame_start_o) begin
        chk("R6 frame start with shift", int'(shift_o), 1);
        chk("R6 frame start at left level", int'(lrclk_o), int'(linv));
        if (have_fs) begin
          if (exp_q.size() == 0) begin
            chk("R3 unexpected frame", 0, 1);
          end else begin
            cur_e = exp_q.pop_front();
            chk("R3 frame length in master cycles", cyc_cnt, cur_e.period);
            chk("R7 bclk edges per frame", edge_cnt, cur_e.edges);
            chk("R4 left-level cycles per frame", left_cnt, cur_e.left);
          end
        end
        have_fs = 1'b1;
        cyc_cnt = 0;
        edge_cnt = 0;
        left_cnt = 0;
      end
    end else begin
      have_sh = 1'b0;
      have_fs = 1'b0;
      cyc_cnt = 0;
      edge_cnt = 0;
      left_cnt = 0;
    end
    if (mon_s) begin
      if (shift_o) sh_cnt++;
      if (sample_o) sa_cnt++;
      if (frame_start_o) begin
        fs_cnt++;
        if (!shift_o) fs_bad++;
      end
      if (shift_o && sample_o) viol11++;
      if (bclk_o || lrclk_o || clk_oe_o) drv_bad++;
    end
    prev_b = bclk_o;
    prev_l = lrclk_o;
  end

  task automatic check_idle();
    chk("R1 idle bclk level", int'(bclk_o), int'(binv));
    chk("R1 idle lrclk level", int'(lrclk_o), int'(linv));
    chk("R1 idle strobes", int'({shift_o, sample_o, frame_start_o}), 0);
  endtask

  task automatic setup(input logic md, input logic [1:0] fd, input logic bi,
                       input logic li, input logic fr);
    @(negedge clk);
    en = 1'b0; mst = 1'b1; mdiv = md; fdiv = fd; binv = bi; linv = li; frun = fr;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_frames(input int nfr);
    int per, r, ed;
    per = mdiv ? 4 : 2;
    r = (fdiv == 2'd0) ? 32 : (fdiv == 2'd1) ? 64 : 128;
    ed = frun ? r : 2 * ((ACT < r / 2) ? ACT : r / 2);
    exp_per = per;
    for (int k = 0; k < nfr; k++) exp_q.push_back('{per * r, ed, per * r / 2});
  endtask

  task automatic start_run();
    first_pend = 1'b1;
    en = 1'b1;
    mon_m = 1'b1;
  endtask

  task automatic stop_and_check();
    while (exp_q.size() != 0) @(negedge clk);
    en = 1'b0;
    mon_m = 1'b0;
    repeat (2) @(negedge clk);
    check_idle();
    chk("R11 shift and sample never together", viol11, 0);
    viol11 = 0;
  endtask

  task automatic run_master(input logic md, input logic [1:0] fd, input logic bi,
                            input logic li, input logic fr, input int nfr);
    setup(md, fd, bi, li, fr);
    push_frames(nfr);
    start_run();
    stop_and_check();
  endtask

  task automatic run_slave(input logic bi, input logic li);
    bit rgt;
    @(negedge clk);
    en = 1'b0; mst = 1'b0; binv = bi; linv = li;
    ext_b = ~bi;
    ext_l = ~li;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (6) @(negedge clk);
    sh_cnt = 0; sa_cnt = 0; fs_cnt = 0; drv_bad = 0; fs_bad = 0;
    mon_s = 1'b1;
    for (int b = 0; b < 132; b++) begin
      rgt = (b < 4) ? 1'b1 : (((b - 4) % 64) >= 32);
      ext_b = bi;
      ext_l = rgt ? ~li : li;
      repeat (4) @(negedge clk);
      ext_b = ~bi;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    mon_s = 1'b0;
    en = 1'b0;
    chk("R9 one shift strobe per external shift edge", sh_cnt, 132);
    chk("R9 one sample strobe per external sample edge", sa_cnt, 132);
    chk("R9 clocks not driven in slave mode", drv_bad, 0);
    chk("R10 frame starts on right-to-left change", fs_cnt, 2);
    chk("R10 frame start always with shift", fs_bad, 0);
    chk("R11 slave strobes exclusive", viol11, 0);
    viol11 = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bclk low", int'(bclk_o), 0);
    chk("R1 reset lrclk low", int'(lrclk_o), 0);
    chk("R1 reset strobes low", int'({shift_o, sample_o, frame_start_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle();

    run_master(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 3);
    run_master(1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 3);
    run_master(1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 3);
    run_master(1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 3);
    run_master(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 3);

    // R8: stop in mid-frame, then restart; the new frame must open with the left word.
    setup(1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
    exp_per = 2;
    start_run();
    repeat (50) @(negedge clk);
    en = 1'b0;
    mon_m = 1'b0;
    repeat (2) @(negedge clk);
    check_idle();
    push_frames(2);
    start_run();
    stop_and_check();

    run_slave(1'b0, 1'b0);
    run_slave(1'b1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule